// File: doc/BRIEF.md
# Configuration Space Access Decoder

This block turns a configuration-space request (bus number, slot, function, register offset, access width, and read or write) into one access on a flat memory port that covers a fixed configuration window. The address is built from the request fields. Requests for buses other than the root bus land in a second region inside the same window. Sub-dword accesses are placed on the correct byte lanes of a little-endian 32-bit data path, and writes carry byte enables.

A bitmap of populated root-bus slots is loaded by software. Root-bus requests that target an empty slot, or any function other than 0, never reach the memory port. Requests with an unsupported width or alignment are also kept off the port. A stopped read still returns a response, which is all ones; a stopped write is silently dropped.

The block handles one request at a time. It accepts a request when `req_valid` and `req_ready` are both high. A read result comes back as a one-cycle `rsp_valid` pulse. A write gets no response.

Top module: `cfgx_access_unit`

## Requirements
- R1: On the root bus (bus 0), the memory address is WIN_BASE plus the window offset. The offset is slot in bits 15:11, function in bits 10:8 and register in bits 7:0. Bits 1:0 of the address are always 0, because lanes are chosen with byte enables.
- R2: When the bus number is nonzero, 0x0100_0000 plus (bus << 16) is added to the address. The populated-slot filter does not apply to such requests.
- R3: A read on bus 0 is stopped when its slot is not populated or its function is nonzero. It makes no memory-port access and returns 0xFFFF_FFFF.
- R4: A write on bus 0 is dropped when its slot is not populated or its function is nonzero. It makes no memory-port access, and the block is ready again on the next cycle.
- R5: `req_width` holds the byte count. Only 1, 2 and 4 are accepted. A 2-byte access must have reg[0]=0, and a 4-byte access must have reg[1:0]=0. Any other request makes no access: a read returns 0xFFFF_FFFF and a write is dropped.
- R6: The window is little-endian: the byte at address offset k (k = reg[1:0]) uses lane k, which is bits 8k+7..8k. `mem_be` is 0001<<k for 1 byte, 0011<<k for 2 bytes, and 1111 for 4 bytes. Write data is the request value shifted up by 8k bits.
- R7: Read data is returned right-justified: the raw word shifted down by 8k bits, with the bits above the access width set to zero.
- R8: The populated-slot bitmap (bit s = slot s) is empty after reset and is replaced as a whole on a cycle with `slot_map_we` high.
- R9: `req_ready` is low from acceptance until the request is finished. A forwarded read raises `rsp_valid` for exactly one cycle, in the cycle after `mem_rvalid`. A stopped read raises `rsp_valid` in the cycle after acceptance.
- R10: `mem_req`, `mem_we`, `mem_addr`, `mem_be` and `mem_wdata` stay stable from when `mem_req` rises until the cycle in which `mem_gnt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_map_we | input | 1 | Load the populated-slot bitmap |
| slot_map_wdata | input | NUM_SLOTS | New bitmap value, bit s = slot s |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | BUS_W | Bus number |
| req_slot | input | SLOT_W | Slot (device) number |
| req_func | input | FUNC_W | Function number |
| req_reg | input | REG_W | Register byte offset |
| req_width | input | 3 | Access width in bytes |
| req_wdata | input | 32 | Write value, right-justified |
| rsp_valid | output | 1 | Read result valid (one-cycle pulse) |
| rsp_rdata | output | 32 | Read result, right-justified |
| mem_req | output | 1 | Memory-port access request |
| mem_gnt | input | 1 | Memory port accepts the access |
| mem_we | output | 1 | Memory-port write |
| mem_addr | output | ADDR_W | Dword-aligned window address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rvalid | input | 1 | Read data from the memory port is valid |
| mem_rdata | input | 32 | Raw little-endian read word |

## Verification
The assertions check on every cycle that:
- the memory-port signals hold while the port stalls;
- the byte enables always form one of the legal lane patterns;
- a filtered or malformed request never raises `mem_req`;
- the response is a single pulse one cycle after `mem_rvalid`.

Only the bench scenarios can show the rest:
- the actual address values for the root bus and for other buses;
- which lanes are used for each width and offset, and the right-justified read results;
- that dropped writes leave the port untouched;
- that reloading the bitmap changes which slots are reachable.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_RESP
   } cfgx_state_e;

   localparam int unsigned LANE_BYTES = 4;
   localparam logic [31:0] ALL_ONES  = 32'hFFFF_FFFF;
endpackage

// File: rtl/cfgx_addr_gen.sv
module cfgx_addr_gen #(
   parameter int unsigned BUS_W      = 8,
   parameter int unsigned SLOT_W     = 5,
   parameter int unsigned FUNC_W     = 3,
   parameter int unsigned REG_W      = 8,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned NUM_SLOTS  = 32,
   parameter logic [31:0] WIN_BASE   = 32'h8000_0000,
   parameter logic [31:0] REMOTE_OFS = 32'h0100_0000
) (
   input  logic [BUS_W-1:0]     bus,
   input  logic [SLOT_W-1:0]    slot,
   input  logic [FUNC_W-1:0]    func,
   input  logic [REG_W-3:0]     reg_dw,
   input  logic [NUM_SLOTS-1:0] slot_map,
   output logic [ADDR_W-1:0]    addr,
   output logic                 blocked
);
   localparam int unsigned LOCAL_W = SLOT_W + FUNC_W + REG_W;

   if (NUM_SLOTS < 2 || NUM_SLOTS > (1 << SLOT_W)) begin : g_bad_slots
      $error("NUM_SLOTS must lie between 2 and 2**SLOT_W");
   end
   if (LOCAL_W + BUS_W > ADDR_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the window offset");
   end

   logic [ADDR_W-1:0] local_ofs;
   logic [ADDR_W-1:0] remote_ofs;
   logic              populated;

   assign local_ofs  = ADDR_W'({slot, func, reg_dw, 2'b00});
   assign remote_ofs = (bus != '0) ? (ADDR_W'(REMOTE_OFS) + (ADDR_W'(bus) << LOCAL_W))
                                   : '0;
   assign addr       = ADDR_W'(WIN_BASE) + local_ofs + remote_ofs;

   if (NUM_SLOTS == (1 << SLOT_W)) begin : g_full_map
      assign populated = slot_map[slot];
   end else begin : g_part_map
      localparam int unsigned IDX_W = $clog2(NUM_SLOTS);
      assign populated = (32'(slot) < NUM_SLOTS) && slot_map[slot[IDX_W-1:0]];
   end

   assign blocked = (bus == '0) && (!populated || (func != '0));
endmodule

// File: rtl/cfgx_lane_steer.sv
module cfgx_lane_steer #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [2:0]        wr_width,
   input  logic [1:0]        wr_lane,
   input  logic [DATA_W-1:0] wr_value,
   output logic              width_ok,
   output logic [3:0]        be,
   output logic [DATA_W-1:0] wr_lanes,
   input  logic [2:0]        rd_width,
   input  logic [1:0]        rd_lane,
   input  logic [DATA_W-1:0] rd_raw,
   output logic [DATA_W-1:0] rd_value
);
   localparam int unsigned BYTES = DATA_W / 8;

   if (DATA_W != 32) begin : g_bad_width
      $error("cfgx_lane_steer supports a 32-bit data path only");
   end

   logic [DATA_W-1:0] rd_shift;

   always_comb begin
      unique case (wr_width)
         3'd1:    width_ok = 1'b1;
         3'd2:    width_ok = !wr_lane[0];
         3'd4:    width_ok = (wr_lane == 2'd0);
         default: width_ok = 1'b0;
      endcase
   end

   for (genvar b = 0; b < BYTES; b++) begin : g_be
      always_comb begin
         unique case (wr_width)
            3'd1:    be[b] = (wr_lane == 2'(b));
            3'd2:    be[b] = ((b / 2) == int'(wr_lane[1]));
            3'd4:    be[b] = 1'b1;
            default: be[b] = 1'b0;
         endcase
      end
   end

   assign wr_lanes = wr_value << {wr_lane, 3'b000};
   assign rd_shift = rd_raw >> {rd_lane, 3'b000};

   always_comb begin
      unique case (rd_width)
         3'd1:    rd_value = {24'h0, rd_shift[7:0]};
         3'd2:    rd_value = {16'h0, rd_shift[15:0]};
         default: rd_value = rd_shift;
      endcase
   end
endmodule

// File: rtl/cfgx_access_unit.sv
module cfgx_access_unit
   import cfgx_pkg::*;
#(
   parameter int unsigned BUS_W      = 8,
   parameter int unsigned SLOT_W     = 5,
   parameter int unsigned FUNC_W     = 3,
   parameter int unsigned REG_W      = 8,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned NUM_SLOTS  = 32,
   parameter logic [31:0] WIN_BASE   = 32'h8000_0000,
   parameter logic [31:0] REMOTE_OFS = 32'h0100_0000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 slot_map_we,
   input  logic [NUM_SLOTS-1:0] slot_map_wdata,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic [BUS_W-1:0]     req_bus,
   input  logic [SLOT_W-1:0]    req_slot,
   input  logic [FUNC_W-1:0]    req_func,
   input  logic [REG_W-1:0]     req_reg,
   input  logic [2:0]           req_width,
   input  logic [31:0]          req_wdata,
   output logic                 rsp_valid,
   output logic [31:0]          rsp_rdata,
   output logic                 mem_req,
   input  logic                 mem_gnt,
   output logic                 mem_we,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [3:0]           mem_be,
   output logic [31:0]          mem_wdata,
   input  logic                 mem_rvalid,
   input  logic [31:0]          mem_rdata
);
   if (REG_W < 3) begin : g_bad_reg
      $error("REG_W must be at least 3");
   end

   cfgx_state_e          state;
   logic [NUM_SLOTS-1:0] slot_map;
   logic [ADDR_W-1:0]    nxt_addr, r_addr;
   logic [3:0]           nxt_be, r_be;
   logic [31:0]          nxt_wdata, r_wdata, rd_value, rsp_q;
   logic                 blocked, width_ok, r_write;
   logic [2:0]           r_width;
   logic [1:0]           r_lane;
   logic                 accept;

   assign accept = req_valid && (state == ST_IDLE);

   cfgx_addr_gen #(
      .BUS_W(BUS_W), .SLOT_W(SLOT_W), .FUNC_W(FUNC_W), .REG_W(REG_W),
      .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .WIN_BASE(WIN_BASE),
      .REMOTE_OFS(REMOTE_OFS)
   ) u_addr (
      .bus(req_bus), .slot(req_slot), .func(req_func),
      .reg_dw(req_reg[REG_W-1:2]), .slot_map(slot_map),
      .addr(nxt_addr), .blocked(blocked)
   );

   cfgx_lane_steer #(.DATA_W(32)) u_lane (
      .wr_width(req_width), .wr_lane(req_reg[1:0]), .wr_value(req_wdata),
      .width_ok(width_ok), .be(nxt_be), .wr_lanes(nxt_wdata),
      .rd_width(r_width), .rd_lane(r_lane), .rd_raw(mem_rdata),
      .rd_value(rd_value)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_map <= '0;
      end else if (slot_map_we) begin
         slot_map <= slot_map_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         r_write <= 1'b0;
         r_addr  <= '0;
         r_be    <= '0;
         r_wdata <= '0;
         r_width <= '0;
         r_lane  <= '0;
         rsp_q   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (accept) begin
               r_write <= req_write;
               r_addr  <= nxt_addr;
               r_be    <= nxt_be;
               r_wdata <= nxt_wdata;
               r_width <= req_width;
               r_lane  <= req_reg[1:0];
               if (blocked || !width_ok) begin
                  if (!req_write) begin
                     rsp_q <= ALL_ONES;
                     state <= ST_RESP;
                  end
               end else begin
                  state <= ST_ISSUE;
               end
            end
            ST_ISSUE: if (mem_gnt) state <= r_write ? ST_IDLE : ST_WAIT;
            ST_WAIT: if (mem_rvalid) begin
               rsp_q <= rd_value;
               state <= ST_RESP;
            end
            ST_RESP: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign mem_req   = (state == ST_ISSUE);
   assign mem_we    = r_write;
   assign mem_addr  = r_addr;
   assign mem_be    = r_be;
   assign mem_wdata = r_wdata;
   assign rsp_valid = (state == ST_RESP);
   assign rsp_rdata = rsp_q;

   p_filtered_no_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (req_bus == '0) &&
       (!slot_map[req_slot] || (req_func != '0))) |=> !mem_req);

   p_dropped_write_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_write && (req_bus == '0) && (req_func != '0))
      |=> (req_ready && !mem_req));

   p_bad_width_no_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (req_width != 3'd1) && (req_width != 3'd2) &&
       (req_width != 3'd4)) |=> !mem_req);

   p_be_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (($countones(mem_be) == 1) || (mem_be == 4'h3) ||
                   (mem_be == 4'hC) || (mem_be == 4'hF)));

   p_rsp_after_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && mem_rvalid) |=> rsp_valid);

   p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   p_hold_while_stalled_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_be) &&
                                  $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: tb/cfgx_access_unit_test.sv
module cfgx_access_unit_test;
   localparam int          CLK_PERIOD = 10;
   localparam logic [31:0] BASE       = 32'h8000_0000;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        slot_map_we = 0;
   logic [31:0] slot_map_wdata = '0;
   logic        req_valid = 0, req_write = 0;
   logic [7:0]  req_bus = '0, req_reg = '0;
   logic [4:0]  req_slot = '0;
   logic [2:0]  req_func = '0, req_width = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, rsp_valid, mem_req, mem_we;
   logic [31:0] rsp_rdata, mem_addr, mem_wdata;
   logic [3:0]  mem_be;
   logic        mem_gnt = 0, mem_rvalid = 0;
   logic [31:0] mem_rdata = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfgx_access_unit uut (
      .clk(clk), .rst_n(rst_n), .slot_map_we(slot_map_we),
      .slot_map_wdata(slot_map_wdata), .req_valid(req_valid),
      .req_ready(req_ready), .req_write(req_write), .req_bus(req_bus),
      .req_slot(req_slot), .req_func(req_func), .req_reg(req_reg),
      .req_width(req_width), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .mem_req(mem_req), .mem_gnt(mem_gnt),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   int nchk = 0, nfail = 0;
   bit done = 0;
   int cyc = 0, rv_cyc = 0, grants = 0, stall_left = 0;
   logic [31:0] map_model = '0;

   logic [31:0] rd_exp_q[$];
   bit          rd_fwd_q[$];
   string       rd_tag_q[$];
   logic [31:0] ra_exp_q[$];
   string       ra_tag_q[$];
   logic [31:0] wa_exp_q[$], wd_exp_q[$];
   logic [3:0]  wb_exp_q[$];
   string       wr_tag_q[$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mem_fn(input logic [31:0] a);
      return {a[7:0], a[15:8], a[23:16], a[31:24]} ^ 32'h1234_5678;
   endfunction

   function automatic logic [31:0] exp_addr(input logic [7:0] b, input logic [4:0] s,
                                            input logic [2:0] f, input logic [7:0] r);
      logic [31:0] a;
      a = BASE + {16'h0, s, f, r[7:2], 2'b00};
      if (b != 0) a = a + 32'h0100_0000 + ({24'h0, b} << 16);
      return a;
   endfunction

   always @(posedge clk) cyc++;

   // backend model and write/address scoreboard
   always @(negedge clk) begin
      mem_rvalid = 0;
      if (rd_pend_cnt > 0) begin
         rd_pend_cnt--;
         if (rd_pend_cnt == 0) begin
            mem_rvalid = 1;
            mem_rdata  = mem_fn(rd_pend_addr);
            rv_cyc     = cyc;
         end
      end
      mem_gnt = 0;
      if (rst_n && mem_req) begin
         if (stall_left > 0) stall_left--;
         else begin
            mem_gnt = 1;
            grants++;
            if (mem_we) begin
               if (wa_exp_q.size() == 0) chk("unexpected write R4", mem_addr, 32'hx);
               else begin
                  string t;
                  logic [31:0] bm;
                  t  = wr_tag_q.pop_front();
                  bm = {{8{wb_exp_q[0][3]}}, {8{wb_exp_q[0][2]}},
                        {8{wb_exp_q[0][1]}}, {8{wb_exp_q[0][0]}}};
                  chk({t, " wr addr"}, mem_addr, wa_exp_q.pop_front());
                  chk({t, " wr be"}, {28'h0, mem_be}, {28'h0, wb_exp_q.pop_front()});
                  chk({t, " wr data"}, mem_wdata & bm, wd_exp_q.pop_front());
               end
            end else begin
               rd_pend_cnt  = 2;
               rd_pend_addr = mem_addr;
               if (ra_exp_q.size() == 0) chk("unexpected read R3", mem_addr, 32'hx);
               else chk({ra_tag_q.pop_front(), " rd addr"}, mem_addr, ra_exp_q.pop_front());
            end
         end
      end
   end
   int          rd_pend_cnt = 0;
   logic [31:0] rd_pend_addr = '0;

   // response monitor
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (rd_exp_q.size() == 0) chk("unexpected response R9", rsp_rdata, 32'hx);
         else begin
            string t;
            t = rd_tag_q.pop_front();
            chk({t, " rd data"}, rsp_rdata, rd_exp_q.pop_front());
            if (rd_fwd_q.pop_front()) chk("R9 rsp one cycle after rvalid", cyc - rv_cyc, 1);
         end
      end
   end

   task automatic load_map(input logic [31:0] m);
      @(negedge clk);
      slot_map_we = 1; slot_map_wdata = m;
      @(negedge clk);
      slot_map_we = 0;
      map_model = m;
   endtask

   task automatic op(input bit wr, input logic [7:0] b, input logic [4:0] s,
                     input logic [2:0] f, input logic [7:0] r, input logic [2:0] w,
                     input logic [31:0] wd, input string tag, input int stall);
      bit blocked, ok, fwd;
      int sh;
      logic [31:0] a, wm, v;
      logic [3:0] be;
      int g0;
      blocked = (b == 0) && (!map_model[s] || f != 0);
      ok = (w == 1) || (w == 2 && !r[0]) || (w == 4 && r[1:0] == 0);
      fwd = !blocked && ok;
      sh = 8 * r[1:0];
      a = exp_addr(b, s, f, r);
      wm = (w == 1) ? 32'hFF : (w == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
      be = (w == 1) ? (4'b0001 << r[1:0]) : (w == 2) ? (4'b0011 << r[1:0]) : 4'hF;
      while (!req_ready) @(negedge clk);
      g0 = grants;
      stall_left = stall;
      if (wr) begin
         if (fwd) begin
            wa_exp_q.push_back(a); wb_exp_q.push_back(be);
            wd_exp_q.push_back((wd & wm) << sh); wr_tag_q.push_back(tag);
         end
      end else begin
         if (fwd) begin
            ra_exp_q.push_back(a); ra_tag_q.push_back(tag);
            v = (mem_fn(a) >> sh) & wm;
         end else v = 32'hFFFF_FFFF;
         rd_exp_q.push_back(v); rd_fwd_q.push_back(fwd); rd_tag_q.push_back(tag);
      end
      req_valid = 1; req_write = wr; req_bus = b; req_slot = s; req_func = f;
      req_reg = r; req_width = w; req_wdata = wd;
      @(negedge clk);
      req_valid = 0;
      if (!wr || fwd) chk({tag, " R9 busy after accept"}, {31'h0, req_ready}, 0);
      else chk({tag, " R4 ready after dropped write"}, {31'h0, req_ready}, 1);
      while (!(req_ready && rd_exp_q.size() == 0 && wa_exp_q.size() == 0 &&
               ra_exp_q.size() == 0)) @(negedge clk);
      if (wr && !fwd) begin
         repeat (4) @(negedge clk);
         chk({tag, " no backend access"}, grants - g0, 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R9 reset ready", {31'h0, req_ready}, 1);
      chk("R9 reset rsp_valid", {31'h0, rsp_valid}, 0);
      chk("R10 reset mem_req", {31'h0, mem_req}, 0);
      op(0, 8'd0, 5'd0, 3'd0, 8'h00, 3'd4, 0, "R8 empty map read", 0);
      load_map(32'h0000_0105);
      op(0, 8'd0, 5'd2, 3'd0, 8'h00, 3'd4, 0, "R1 R7 dword read", 0);
      op(0, 8'd0, 5'd8, 3'd0, 8'h0E, 3'd2, 0, "R6 R7 half read", 0);
      op(0, 8'd0, 5'd0, 3'd0, 8'h43, 3'd1, 0, "R6 R7 byte read", 0);
      op(0, 8'd0, 5'd1, 3'd0, 8'h00, 3'd4, 0, "R3 empty slot read", 0);
      op(0, 8'd0, 5'd2, 3'd3, 8'h00, 3'd4, 0, "R3 func3 read", 0);
      op(1, 8'd0, 5'd5, 3'd0, 8'h10, 3'd4, 32'hDEAD_BEEF, "R4 empty slot write", 0);
      op(1, 8'd0, 5'd2, 3'd1, 8'h10, 3'd4, 32'hDEAD_BEEF, "R4 func1 write", 0);
      op(1, 8'd0, 5'd2, 3'd0, 8'h11, 3'd1, 32'h0000_00AB, "R6 byte write", 0);
      op(1, 8'd0, 5'd8, 3'd0, 8'h3C, 3'd4, 32'hCAFE_F00D, "R6 dword write", 0);
      op(1, 8'd3, 5'd5, 3'd4, 8'h22, 3'd2, 32'h0000_BEEF, "R2 remote half write", 0);
      op(0, 8'hFF, 5'd31, 3'd7, 8'hFC, 3'd4, 0, "R2 remote dword read", 0);
      op(0, 8'd1, 5'd0, 3'd0, 8'h81, 3'd1, 0, "R2 remote byte read", 0);
      op(0, 8'd0, 5'd2, 3'd0, 8'h00, 3'd3, 0, "R5 width3 read", 0);
      op(0, 8'd0, 5'd2, 3'd0, 8'h00, 3'd0, 0, "R5 width0 read", 0);
      op(0, 8'd0, 5'd2, 3'd0, 8'h05, 3'd2, 0, "R5 odd half read", 0);
      op(0, 8'd0, 5'd2, 3'd0, 8'h02, 3'd4, 0, "R5 unaligned dword read", 0);
      op(1, 8'd0, 5'd2, 3'd0, 8'h00, 3'd3, 32'h1111_2222, "R5 width3 write", 0);
      op(0, 8'd0, 5'd2, 3'd0, 8'h16, 3'd2, 0, "R10 stalled read", 3);
      op(1, 8'd2, 5'd9, 3'd2, 8'h47, 3'd1, 32'h0000_0077, "R10 stalled write", 2);
      load_map(32'h8000_0000);
      op(0, 8'd0, 5'd31, 3'd0, 8'h08, 3'd4, 0, "R8 new slot read", 0);
      op(0, 8'd0, 5'd2, 3'd0, 8'h00, 3'd4, 0, "R8 removed slot read", 0);
      op(1, 8'd0, 5'd2, 3'd0, 8'h00, 3'd4, 32'h5555_AAAA, "R8 removed slot write", 0);
      repeat (5) @(negedge clk);
      chk("R9 queues drained", rd_exp_q.size() + wa_exp_q.size() + ra_exp_q.size(), 0);
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog expired R9 actual=hung expected=finished");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end
endmodule